// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block sits in the read path of a byte-wide flash device. An internal program or erase can be running, or an erase can be suspended. While that is so, the block replaces the array byte on the data outputs with an in-band status word. Software learns that the device is busy in two ways. Bit 7 carries the inverse of the bit being written, or a zero while an erase is running. Bit 6 flips on every read strobe. When no operation is active, the array byte passes through untouched.

The command decoder supplies the operation state, bit 7 of the byte being programmed and the mask of sectors chosen for erase. The array supplies the byte at the current read address. The block gets the sector field of that address, the chip-enable and output-enable strobes and a clock. It samples output enable on the clock, so a read strobe must span at least one rising edge.

Top module: `status_reporter`

## Requirements
- R1: With the operation state idle (code 0), `dq` equals `arrayData` on every bit.
- R2: With the state at program (code 1), `dq[7]` is the inverse of `progMsb`, at every sector address.
- R3: When a program ends and the state returns to idle, `dq` shows the array byte in the same cycle. This includes the true (non-inverted) bit 7 of the written data.
- R4: With the state at erase (code 2), a read from a sector whose bit is set in `eraseMask` gives `dq[7]` = 0. Sector i maps to mask bit i, and several mask bits may be set.
- R5: With the state at erase, a read from a sector whose mask bit is clear returns `arrayData`.
- R6: Whenever a status word is driven, `dq[6]` carries the toggle bit and `dq[5:0]` are zero.
- R7: In program or erase, a falling edge of `oeN` with `ceN` low inverts the toggle bit exactly once. The new value shows on `dq[6]` from the first rising clock edge at which the low `oeN` is sampled.
- R8: A falling edge of `oeN` while `ceN` is high leaves the toggle bit unchanged.
- R9: In idle or erase-suspended state (code 3), read strobes leave the toggle bit unchanged.
- R10: In erase-suspended state, reads from sectors outside `eraseMask` return `arrayData`.
- R11: In erase-suspended state, reads from a sector inside `eraseMask` return a status word with `dq[7]` = 1 and the frozen toggle on `dq[6]`.
- R12: Reset clears the toggle bit to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the strobes |
| rstN | input | 1 | Active-low synchronous reset |
| opState | input | 2 | 0 idle, 1 program, 2 erase, 3 erase suspended |
| progMsb | input | 1 | Bit 7 of the byte being programmed |
| eraseMask | input | 8 | One bit per sector selected for erase |
| rdSector | input | 3 | Sector field of the read address |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| arrayData | input | 8 | Byte read from the array |
| dq | output | 8 | Byte driven on the data outputs |

## Verification
The choice between status and array data, and the status bits themselves, are combinational. A new operation state, sector or array byte is therefore visible in the cycle it is applied. The bench drives these inputs on a falling clock edge and checks them two nanoseconds later, before the next rising edge. The toggle bit passes through one register after the strobe edge-detect. A read pulls `oeN` low on a falling edge and samples `dq` on the following falling edge, after exactly one rising edge. It then releases the strobe, so the next read has a fresh falling edge.

// File: rtl/status_reporter_pkg.sv
package status_reporter_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_SUSP  = 2'd3
  } opStateT;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic useStatus;     // drive status word instead of array byte
    logic pollFromData;  // bit 7 from the inverted programmed bit
    logic pollConst;     // bit 7 value when not taken from data
    logic advance;       // invert toggle bit at the next edge
  } strobeT;

endpackage

// File: rtl/status_reporter_ctrl.sv
module status_reporter_ctrl
  import status_reporter_pkg::*;
#(
  parameter int SECT_W = 3,
  localparam int NUM_SECT = 1 << SECT_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  opStateT             opState,
  input  logic [NUM_SECT-1:0] eraseMask,
  input  logic [SECT_W-1:0]   rdSector,
  input  logic                ceN,
  input  logic                oeN,
  output strobeT              strobes
);

  logic oePrevQ;
  logic busy;
  logic inErase;

  always_ff @(posedge clk) begin
    if (!rstN) oePrevQ <= 1'b1;
    else       oePrevQ <= oeN;
  end

  assign busy    = (opState == OP_PROG) || (opState == OP_ERASE);
  assign inErase = eraseMask[rdSector];

  always_comb begin
    strobes              = '0;
    strobes.advance      = busy && oePrevQ && !oeN && !ceN;
    case (opState)
      OP_PROG: begin
        strobes.useStatus    = 1'b1;
        strobes.pollFromData = 1'b1;
      end
      OP_ERASE: begin
        strobes.useStatus = inErase;
        strobes.pollConst = 1'b0;
      end
      OP_SUSP: begin
        strobes.useStatus = inErase;
        strobes.pollConst = 1'b1;
      end
      default: strobes.useStatus = 1'b0;
    endcase
  end

  AST_NO_ADV_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (opState == OP_IDLE || opState == OP_SUSP) |-> !strobes.advance); // R9

endmodule

// File: rtl/status_reporter_dp.sv
module status_reporter_dp
  import status_reporter_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobes,
  input  logic              progMsb,
  input  logic [DATA_W-1:0] arrayData,
  output logic              toggleQ,
  output logic [DATA_W-1:0] dq
);

  localparam int LOW_W = DATA_W - 2;

  logic pollBit;

  always_ff @(posedge clk) begin
    if (!rstN)                toggleQ <= 1'b0;
    else if (strobes.advance) toggleQ <= ~toggleQ;
  end

  assign pollBit = strobes.pollFromData ? ~progMsb : strobes.pollConst;
  assign dq      = strobes.useStatus ? {pollBit, toggleQ, {LOW_W{1'b0}}} : arrayData;

  AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobes.useStatus |-> (dq[LOW_W-1:0] == '0 && dq[DATA_W-2] == toggleQ)); // R6

endmodule

// File: rtl/status_reporter.sv
module status_reporter
  import status_reporter_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SECT_W = 3,
  localparam int NUM_SECT = 1 << SECT_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          opState,
  input  logic                progMsb,
  input  logic [NUM_SECT-1:0] eraseMask,
  input  logic [SECT_W-1:0]   rdSector,
  input  logic                ceN,
  input  logic                oeN,
  input  logic [DATA_W-1:0]   arrayData,
  output logic [DATA_W-1:0]   dq
);

  strobeT strobes;
  logic   toggleBit;
  logic   busyNow;

  status_reporter_ctrl #(.SECT_W(SECT_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .opState   (opStateT'(opState)),
    .eraseMask (eraseMask),
    .rdSector  (rdSector),
    .ceN       (ceN),
    .oeN       (oeN),
    .strobes   (strobes)
  );

  status_reporter_dp #(.DATA_W(DATA_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .progMsb   (progMsb),
    .arrayData (arrayData),
    .toggleQ   (toggleBit),
    .dq        (dq)
  );

  assign busyNow = (opState == OP_PROG) || (opState == OP_ERASE);

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (opState == OP_IDLE) |-> (dq == arrayData)); // R1
  AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rstN)
    (opState == OP_PROG) |-> (dq[DATA_W-1] == ~progMsb)); // R2
  AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rstN)
    (opState == OP_ERASE && eraseMask[rdSector]) |-> (dq[DATA_W-1] == 1'b0)); // R4
  AST_SUSP_OUTSIDE: assert property (@(posedge clk) disable iff (!rstN)
    (opState == OP_SUSP && !eraseMask[rdSector]) |-> (dq == arrayData)); // R10
  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    (busyNow && !ceN && !oeN && $past(oeN)) |=> (toggleBit != $past(toggleBit))); // R7
  AST_CE_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    ceN |=> $stable(toggleBit)); // R8
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (opState == OP_IDLE || opState == OP_SUSP) |=> $stable(toggleBit)); // R9

endmodule

// File: tb/status_reporter_tb_top.sv
`timescale 1ns/1ps
module status_reporter_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] opState = 2'd0;
  logic       progMsb = 1'b0;
  logic [7:0] eraseMask = 8'h00;
  logic [2:0] rdSector = 3'd0;
  logic       ceN = 1'b1;
  logic       oeN = 1'b1;
  logic [7:0] arrayData = 8'h00;
  logic [7:0] dq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  status_reporter dut_i (
    .clk(clk), .rstN(rstN), .opState(opState), .progMsb(progMsb),
    .eraseMask(eraseMask), .rdSector(rdSector), .ceN(ceN), .oeN(oeN),
    .arrayData(arrayData), .dq(dq)
  );

  // {opState, rdSector, progMsb, eraseMask, arrayData, expected dq}, toggle bit 0
  localparam logic [29:0] VEC [0:9] = '{
    {2'd0, 3'd1, 1'b0, 8'h00, 8'hA5, 8'hA5},  // R1 idle pass-through
    {2'd1, 3'd1, 1'b1, 8'h00, 8'h33, 8'h00},  // R2 R6 program, bit 7 inverted
    {2'd1, 3'd5, 1'b0, 8'h00, 8'h33, 8'h80},  // R2 other sector, data bit 0
    {2'd2, 3'd2, 1'b0, 8'h04, 8'h5A, 8'h00},  // R4 erase inside mask
    {2'd2, 3'd3, 1'b0, 8'h04, 8'h5A, 8'h5A},  // R5 erase outside mask
    {2'd2, 3'd7, 1'b0, 8'h81, 8'hFF, 8'h00},  // R4 multi-sector, top sector
    {2'd2, 3'd0, 1'b0, 8'h81, 8'hFF, 8'h00},  // R4 multi-sector, sector 0
    {2'd3, 3'd7, 1'b0, 8'h04, 8'hC3, 8'hC3},  // R10 suspended, outside
    {2'd3, 3'd2, 1'b0, 8'h04, 8'hC3, 8'h80},  // R11 suspended, inside
    {2'd0, 3'd5, 1'b1, 8'h00, 8'hF0, 8'hF0}   // R3 program done, true bit 7
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: dq=%02h expected %02h", req, got, exp);
    end
  endtask

  task automatic setOp(input logic [1:0] op, input logic [2:0] sec, input logic pm,
                       input logic [7:0] mask, input logic [7:0] arr);
    @(negedge clk);
    opState = op; rdSector = sec; progMsb = pm; eraseMask = mask; arrayData = arr;
    #2;
  endtask

  // one read strobe: low across exactly one rising edge, sampled before release
  task automatic doRead(input logic ceLevel, output logic [7:0] seen);
    @(negedge clk);
    ceN = ceLevel; oeN = 1'b0;
    @(negedge clk);
    #1;
    seen = dq;
    ceN = 1'b1; oeN = 1'b1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] seen;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R12 reset state: toggle bit 0 in an erase status word
    setOp(2'd2, 3'd2, 1'b0, 8'h04, 8'h00);
    check("R12 reset toggle", dq, 8'h00);

    for (int i = 0; i < 10; i++) begin
      setOp(VEC[i][29:28], VEC[i][27:25], VEC[i][24], VEC[i][23:16], VEC[i][15:8]);
      check($sformatf("vector %0d (R1-R6,R10,R11 table)", i), dq, VEC[i][7:0]);
    end

    // R7 successive reads during erase toggle bit 6
    setOp(2'd2, 3'd2, 1'b0, 8'h04, 8'h00);
    doRead(1'b0, seen); check("R7 first read", seen, 8'h40);
    doRead(1'b0, seen); check("R7 second read", seen, 8'h00);
    doRead(1'b0, seen); check("R7 third read", seen, 8'h40);

    // R8 strobe with chip enable high
    doRead(1'b1, seen); check("R8 ce high", seen, 8'h40);

    // R9 idle reads leave toggle alone
    setOp(2'd0, 3'd2, 1'b0, 8'h04, 8'h11);
    doRead(1'b0, seen); check("R9 idle read", seen, 8'h11);
    setOp(2'd2, 3'd2, 1'b0, 8'h04, 8'h11);
    check("R9 toggle kept after idle", dq, 8'h40);

    // R9 R11 suspended reads freeze toggle
    setOp(2'd3, 3'd2, 1'b0, 8'h04, 8'h11);
    doRead(1'b0, seen); check("R11 suspended inside", seen, 8'hC0);
    doRead(1'b0, seen); check("R9 suspended frozen", seen, 8'hC0);

    // R7 program toggles too
    setOp(2'd1, 3'd4, 1'b0, 8'h00, 8'h11);
    doRead(1'b0, seen); check("R7 program read", seen, 8'h80);
    doRead(1'b0, seen); check("R7 program read 2", seen, 8'hC0);

    // R12 reset clears a set toggle
    doReset();
    #3;
    check("R12 after reset", dq, 8'h80);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule